// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This block keeps two independent 16-bit address pointers for an 8-bit processor core. Both pointers live in special-function-register space, one byte per address. A one-bit select register picks which pointer the core's pointer-based instructions use. The select register sits at its own SFR address.

The core reaches the block in two ways:

- **SFR port.** An 8-bit address, a write strobe and 8-bit data read or write any pointer byte or the select register, whatever the select value is.
- **Instruction path.** An increment command and a 16-bit load command act only on the selected pointer.

The selected pointer drives a 16-bit output that the memory access logic uses as its address. Reads on the SFR port and the pointer output are combinational from the registers.

Top module: `dptr_pair_unit`

## Requirements
- R1: After reset, both pointers read 0x0000, the select bit is 0 and `ptr_out` is 0x0000.
- R2: Pointer 0 low/high bytes are at SFR 0x82/0x83, and pointer 1 low/high bytes are at 0x84/0x85. Each byte is written on the clock edge with `sfr_we` high. Each byte reads back on `sfr_rdata` whatever the select value is.
- R3: The select bit is bit 0 of the register at SFR 0xA2. Bits 7..1 of that register always read 0, and writing them has no effect.
- R4: `ptr_out` always equals the pointer chosen by the current select bit (0 = pointer 0, 1 = pointer 1).
- R5: `ptr_inc` adds 1 to the selected pointer, carrying from the low byte into the high byte and wrapping 0xFFFF to 0x0000. The other pointer does not change.
- R6: `ptr_load` writes `ptr_load_val` into the selected pointer only.
- R7: When `ptr_load` and `ptr_inc` are both high, the load takes effect and the increment is dropped.
- R8: An SFR write to either byte of the selected pointer suppresses that cycle's increment and load; the written byte takes the data and the other byte keeps its value. An SFR write to the unselected pointer does not block the increment or load of the selected pointer.
- R9: SFR addresses other than 0x82..0x85 and 0xA2 read as 0x00, and writes to them change nothing.
- R10: A write to the select register takes effect from the next cycle. An increment or load in the same cycle acts on the previously selected pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr` (combinational) |
| ptr_inc | input | 1 | Increment the selected pointer |
| ptr_load | input | 1 | Load the selected pointer with `ptr_load_val` |
| ptr_load_val | input | 16 | Value for the load command |
| ptr_out | output | 16 | Currently selected pointer |

## Verification
A corrupted pointer or select bit shows on `ptr_out` in the cycle after the faulty edge if it belongs to the selected pointer. It also shows on `sfr_rdata` as soon as the affected address is presented. A fault in the unselected pointer stays hidden on `ptr_out` until the select bit flips. The bench therefore reads back all five mapped addresses, and its random phase keeps toggling the select bit.

The priority rules (SFR write over load, load over increment, old select for same-cycle commands) show up only as one wrong value in one cycle. Directed cases set each collision up deliberately and check the result in the following cycle.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int BYTE_W  = 8;
  localparam int PTR_W   = 2 * BYTE_W;
  localparam int NUM_PTR = 2;
  localparam int SEL_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Next value of a pointer under the increment command (modulo 2^PTR_W).
  function automatic ptr_t ptr_step(input ptr_t v);
    return v + ptr_t'(1);
  endfunction

  // Replace one byte of a pointer; hi selects the upper byte.
  function automatic ptr_t ptr_put_byte(input ptr_t v, input logic hi, input byte_t b);
    ptr_t r;
    r = v;
    if (hi) r[PTR_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]     = b;
    return r;
  endfunction

  // Extract one byte of a pointer.
  function automatic byte_t ptr_get_byte(input ptr_t v, input logic hi);
    return hi ? v[PTR_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/dptr_sfr_decode.sv
module dptr_sfr_decode
  import dptr_pkg::*;
#(
  parameter logic [7:0] PTR_BASE_ADDR = 8'h82,
  parameter logic [7:0] SEL_ADDR      = 8'hA2
) (
  input  logic [7:0]         addr,
  output logic [NUM_PTR-1:0] lo_hit,
  output logic [NUM_PTR-1:0] hi_hit,
  output logic               sel_hit,
  output logic               mapped
);
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr_addr
    localparam logic [7:0] LO_A = 8'(PTR_BASE_ADDR + 2 * i);
    localparam logic [7:0] HI_A = 8'(PTR_BASE_ADDR + 2 * i + 1);
    assign lo_hit[i] = (addr == LO_A);
    assign hi_hit[i] = (addr == HI_A);
  end

  assign sel_hit = (addr == SEL_ADDR);
  assign mapped  = sel_hit | (|lo_hit) | (|hi_hit);
endmodule

// File: rtl/dptr_reg.sv
module dptr_reg
  import dptr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_lo,
  input  logic  wr_hi,
  input  byte_t wdata,
  input  logic  is_sel,
  input  logic  inc,
  input  logic  load,
  input  ptr_t  load_val,
  output ptr_t  value
);
  ptr_t value_q;
  ptr_t value_d;
  logic sfr_touch;

  assign sfr_touch = wr_lo | wr_hi;

  // Priority: SFR byte write, then load, then increment (the last two only when selected).
  always_comb begin
    value_d = value_q;
    if (sfr_touch)            value_d = ptr_put_byte(value_q, wr_hi, wdata);
    else if (is_sel && load)  value_d = load_val;
    else if (is_sel && inc)   value_d = ptr_step(value_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= value_d;
  end

  assign value = value_q;
endmodule

// File: rtl/dptr_rd_mux.sv
module dptr_rd_mux
  import dptr_pkg::*;
(
  input  logic [NUM_PTR-1:0]            lo_hit,
  input  logic [NUM_PTR-1:0]            hi_hit,
  input  logic                          sel_hit,
  input  logic [SEL_W-1:0]              sel_q,
  input  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs,
  output byte_t                         rdata
);
  always_comb begin
    rdata = '0;
    if (sel_hit) rdata = BYTE_W'(sel_q);
    for (int i = 0; i < NUM_PTR; i++) begin
      if (lo_hit[i]) rdata = ptr_get_byte(ptrs[i], 1'b0);
      if (hi_hit[i]) rdata = ptr_get_byte(ptrs[i], 1'b1);
    end
  end
endmodule

// File: rtl/dptr_pair_unit.sv
module dptr_pair_unit
  import dptr_pkg::*;
#(
  parameter logic [7:0] PTR_BASE_ADDR = 8'h82,
  parameter logic [7:0] SEL_ADDR      = 8'hA2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sfr_addr,
  input  logic        sfr_we,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        ptr_inc,
  input  logic        ptr_load,
  input  logic [15:0] ptr_load_val,
  output logic [15:0] ptr_out
);
  logic [NUM_PTR-1:0]            lo_hit, hi_hit;
  logic [NUM_PTR-1:0]            wr_lo, wr_hi;
  logic                          sel_hit, addr_mapped;
  logic                          sel_wr;
  logic                          wr_hits_sel;
  logic [SEL_W-1:0]              sel_q;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptr_q;

  dptr_sfr_decode #(
    .PTR_BASE_ADDR(PTR_BASE_ADDR),
    .SEL_ADDR     (SEL_ADDR)
  ) u_decode (
    .addr   (sfr_addr),
    .lo_hit (lo_hit),
    .hi_hit (hi_hit),
    .sel_hit(sel_hit),
    .mapped (addr_mapped)
  );

  assign wr_lo       = lo_hit & {NUM_PTR{sfr_we}};
  assign wr_hi       = hi_hit & {NUM_PTR{sfr_we}};
  assign sel_wr      = sel_hit & sfr_we;
  assign wr_hits_sel = wr_lo[sel_q] | wr_hi[sel_q];

  // Select register: only the low SEL_W bits are stored, upper bits are dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= sfr_wdata[SEL_W-1:0];
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    dptr_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_lo[i]),
      .wr_hi   (wr_hi[i]),
      .wdata   (sfr_wdata),
      .is_sel  (sel_q == SEL_W'(i)),
      .inc     (ptr_inc),
      .load    (ptr_load),
      .load_val(ptr_load_val),
      .value   (ptr_q[i])
    );
  end

  dptr_rd_mux u_rd (
    .lo_hit (lo_hit),
    .hi_hit (hi_hit),
    .sel_hit(sel_hit),
    .sel_q  (sel_q),
    .ptrs   (ptr_q),
    .rdata  (sfr_rdata)
  );

  assign ptr_out = ptr_q[sel_q];
endmodule

// File: rtl/dptr_pair_checker.sv
module dptr_pair_checker #(
  parameter logic [7:0] PTR_BASE_ADDR = 8'h82,
  parameter logic [7:0] SEL_ADDR      = 8'hA2
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sfr_addr,
  input logic        sfr_we,
  input logic [7:0]  sfr_wdata,
  input logic [7:0]  sfr_rdata,
  input logic        ptr_inc,
  input logic        ptr_load,
  input logic [15:0] ptr_load_val,
  input logic [15:0] ptr_out,
  input logic        sel_wr,
  input logic        wr_hits_sel,
  input logic        addr_mapped
);
  logic [7:0] addr_off;
  assign addr_off = sfr_addr - PTR_BASE_ADDR;

  p_inc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load && !wr_hits_sel && !sel_wr) |=> (ptr_out == $past(ptr_out) + 16'd1));

  p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load && !wr_hits_sel && !sel_wr) |=> (ptr_out == $past(ptr_load_val)));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sfr_we && !ptr_inc && !ptr_load) |=> $stable(ptr_out));

  p_sel_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == SEL_ADDR) |-> (sfr_rdata[7:1] == 7'd0));

  p_sfr_write_wins_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && wr_hits_sel && !addr_off[0]) |=>
      (ptr_out[7:0] == $past(sfr_wdata) && ptr_out[15:8] == $past(ptr_out[15:8])));

  p_sfr_write_wins_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && wr_hits_sel && addr_off[0]) |=>
      (ptr_out[15:8] == $past(sfr_wdata) && ptr_out[7:0] == $past(ptr_out[7:0])));

  p_unmapped_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mapped |-> (sfr_rdata == 8'h00));
endmodule

bind dptr_pair_unit dptr_pair_checker #(
  .PTR_BASE_ADDR(PTR_BASE_ADDR),
  .SEL_ADDR     (SEL_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sfr_addr    (sfr_addr),
  .sfr_we      (sfr_we),
  .sfr_wdata   (sfr_wdata),
  .sfr_rdata   (sfr_rdata),
  .ptr_inc     (ptr_inc),
  .ptr_load    (ptr_load),
  .ptr_load_val(ptr_load_val),
  .ptr_out     (ptr_out),
  .sel_wr      (sel_wr),
  .wr_hits_sel (wr_hits_sel),
  .addr_mapped (addr_mapped)
);

// File: tb/dptr_pair_unit_bench.sv
module dptr_pair_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        ptr_inc = 1'b0;
  logic        ptr_load = 1'b0;
  logic [15:0] ptr_load_val = 16'h0000;
  logic [15:0] ptr_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [15:0] m_p0, m_p1;
  logic        m_sel;

  always #5 clk = ~clk;

  dptr_pair_unit u_dptr_pair_unit (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ptr_inc(ptr_inc),
    .ptr_load(ptr_load), .ptr_load_val(ptr_load_val), .ptr_out(ptr_out)
  );

  function automatic logic [7:0] m_read(input logic [7:0] a, input logic [15:0] p0,
                                        input logic [15:0] p1, input logic s);
    case (a)
      8'h82: return p0[7:0];
      8'h83: return p0[15:8];
      8'h84: return p1[7:0];
      8'h85: return p1[15:8];
      8'hA2: return {7'd0, s};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Advance the reference state by the inputs captured at the coming edge.
  task automatic model_step(input logic we, input logic [7:0] a, input logic [7:0] d,
                            input logic inc, input logic ld, input logic [15:0] lv);
    logic old_sel;
    logic blocked;
    old_sel = m_sel;
    blocked = 1'b0;
    if (we) begin
      case (a)
        8'h82: begin m_p0[7:0]  = d; blocked = (old_sel == 1'b0); end
        8'h83: begin m_p0[15:8] = d; blocked = (old_sel == 1'b0); end
        8'h84: begin m_p1[7:0]  = d; blocked = (old_sel == 1'b1); end
        8'h85: begin m_p1[15:8] = d; blocked = (old_sel == 1'b1); end
        8'hA2: m_sel = d[0];
        default: ;
      endcase
    end
    if (!blocked) begin
      if (ld) begin
        if (old_sel) m_p1 = lv; else m_p0 = lv;
      end else if (inc) begin
        if (old_sel) m_p1 = m_p1 + 16'd1; else m_p0 = m_p0 + 16'd1;
      end
    end
  endtask

  // Drive one cycle of stimulus (called at a falling edge), return at the next falling edge.
  task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d,
                     input logic inc, input logic ld, input logic [15:0] lv);
    sfr_we = we; sfr_addr = a; sfr_wdata = d;
    ptr_inc = inc; ptr_load = ld; ptr_load_val = lv;
    model_step(we, a, d, inc, ld, lv);
    @(negedge clk);
    sfr_we = 1'b0; ptr_inc = 1'b0; ptr_load = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    sfr_addr = a;
    #1;
    check(tag, {8'h00, sfr_rdata}, {8'h00, exp});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    m_p0 = 16'h0; m_p1 = 16'h0; m_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ptr_out", ptr_out, 16'h0000);
    rd("R1 p0 lo", 8'h82, 8'h00);
    rd("R1 p1 hi", 8'h85, 8'h00);
    rd("R1 sel", 8'hA2, 8'h00);

    // R2 byte writes and read-back
    cyc(1, 8'h82, 8'h34, 0, 0, 16'h0);
    cyc(1, 8'h83, 8'h12, 0, 0, 16'h0);
    rd("R2 p0 lo", 8'h82, 8'h34);
    rd("R2 p0 hi", 8'h83, 8'h12);
    check("R4 p0 selected", ptr_out, 16'h1234);
    cyc(1, 8'h84, 8'hCD, 0, 0, 16'h0);
    cyc(1, 8'h85, 8'hAB, 0, 0, 16'h0);
    rd("R2 p1 lo", 8'h84, 8'hCD);
    check("R4 unselected write hidden", ptr_out, 16'h1234);

    // R3 select register, upper bits dropped
    cyc(1, 8'hA2, 8'hFF, 0, 0, 16'h0);
    rd("R3 sel readback", 8'hA2, 8'h01);
    check("R4 p1 selected", ptr_out, 16'hABCD);
    rd("R2 p0 lo under sel1", 8'h82, 8'h34);

    // R5 increment with carry and wrap
    cyc(1, 8'h84, 8'hFF, 0, 0, 16'h0);
    cyc(1, 8'h85, 8'h00, 0, 0, 16'h0);
    cyc(0, 8'h00, 8'h00, 1, 0, 16'h0);
    check("R5 carry", ptr_out, 16'h0100);
    rd("R5 other untouched", 8'h83, 8'h12);
    cyc(0, 8'h00, 8'h00, 0, 1, 16'hFFFF);
    cyc(0, 8'h00, 8'h00, 1, 0, 16'h0);
    check("R5 wrap", ptr_out, 16'h0000);

    // R6 load selected only
    cyc(0, 8'h00, 8'h00, 0, 1, 16'hBEEF);
    check("R6 load", ptr_out, 16'hBEEF);
    rd("R6 p0 lo kept", 8'h82, 8'h34);
    rd("R6 p0 hi kept", 8'h83, 8'h12);

    // R7 load over increment
    cyc(0, 8'h00, 8'h00, 1, 1, 16'h5000);
    check("R7 load wins", ptr_out, 16'h5000);

    // R8 SFR write priority
    cyc(1, 8'h84, 8'h77, 1, 0, 16'h0);
    check("R8 write blocks inc", ptr_out, 16'h5077);
    cyc(1, 8'h85, 8'h66, 0, 1, 16'h1111);
    check("R8 write blocks load", ptr_out, 16'h6677);
    cyc(1, 8'h82, 8'h99, 1, 0, 16'h0);
    check("R8 unselected write, inc proceeds", ptr_out, 16'h6678);
    rd("R8 p0 lo written", 8'h82, 8'h99);

    // R9 unmapped addresses
    cyc(1, 8'h86, 8'h55, 0, 0, 16'h0);
    cyc(1, 8'h81, 8'h55, 0, 0, 16'h0);
    cyc(1, 8'hA3, 8'h55, 0, 0, 16'h0);
    rd("R9 read 0x86", 8'h86, 8'h00);
    rd("R9 read 0x81", 8'h81, 8'h00);
    check("R9 ptr unchanged", ptr_out, 16'h6678);
    rd("R9 p0 hi unchanged", 8'h83, 8'h12);
    rd("R9 sel unchanged", 8'hA2, 8'h01);

    // R10 select write with same-cycle increment uses the old select
    cyc(1, 8'hA2, 8'h00, 1, 0, 16'h0);
    check("R10 new select visible", ptr_out, 16'h1299);
    rd("R10 old pointer incremented", 8'h84, 8'h79);

    // Random phase against the reference model
    void'($urandom(32'h1A2B3C4D));
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      case ($urandom % 8)
        0: a = 8'h82; 1: a = 8'h83; 2: a = 8'h84; 3: a = 8'h85;
        4, 5: a = 8'hA2;
        default: a = 8'($urandom);
      endcase
      cyc(1'($urandom % 3 == 0), a, 8'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
          16'($urandom));
      check("R4 random ptr_out", ptr_out, m_sel ? m_p1 : m_p0);
      a = 8'h82 + 8'($urandom % 4);
      if ($urandom % 5 == 0) a = 8'hA2;
      rd("R2 random read", a, m_read(a, m_p0, m_p1, m_sel));
    end

    summary();
  end
endmodule